// File: doc/BRIEF.md
# Chained Statistics Read-Modify-Write Engine

This engine maintains per-route and per-next-hop counters next to a lookup pipeline. Each request carries a result index, a search-hit flag and four field-update descriptors. The index selects a 96-bit first-level word. Two fields of that word are updated, and a 13-bit pointer held inside the word selects a 256-bit second-level word. Two fields in the lower 128 bits of that second word are then updated. Each descriptor sets an enable, a start bit, a length, and whether to add its own operand or a fixed increment.

The engine is a three-stage pipeline and takes one request per cycle. Both levels are small on-chip arrays that are cleared by reset. A request can hit the same first-level entry, or the same second-level entry, as the request directly ahead of it. In that case the update still in flight is forwarded, so no increment is lost. For every request the engine returns the two words as they were read before its own update and raises a done pulse.

Top module: `statrmw_engine`

## Requirements
- R1: After reset, done_o is low, both output words are zero and every entry of both arrays reads as zero.
- R2: A request sampled with valid_i high on a clock edge produces exactly one done_o pulse three rising edges later. A new request may be accepted on every cycle.
- R3: With done_o, old_l1_o carries the first-level word before this request's update and old_l2_o carries the full 256-bit second-level word before this request's update.
- R4: Descriptors 0 and 1 update the first-level word, applied in that order. A descriptor's field spans upd_lenm1_i+1 bits (1 to 32) starting at bit upd_start_i. Bits outside the field are unchanged.
- R5: When upd_cst_i is 1, the descriptor adds the parameter INC (default 1) instead of its operand.
- R6: The second-level address is taken from the low address bits of the 13-bit pointer field at bits 95:83 of the first-level word as read, before this request's update.
- R7: Descriptors 2 and 3 update only bits 127:0 of the second-level word. A field that reaches past bit 127 is truncated there, and bits 255:128 never change.
- R8: A descriptor whose upd_en_i bit is 0 leaves its field unchanged.
- R9: When hit_i is 0, neither array is written, but done_o and both pre-update words are still returned.
- R10: Back-to-back requests to the same first-level index each see the update of the request before them.
- R11: Each add wraps modulo 2 to the power of the field length and does not carry into the neighbouring bits.
- R12: Back-to-back requests with different indices whose pointers select the same second-level word each see the second-level update of the request before them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Request strobe |
| hit_i | input | 1 | Search succeeded; updates are written only when high |
| idx_i | input | IDX_W | First-level index (lookup result) |
| upd_en_i | input | 4 | Per-descriptor enable; descriptors 0 and 1 act on level one, 2 and 3 on level two |
| upd_cst_i | input | 4 | Per-descriptor select: 1 adds INC, 0 adds the operand |
| upd_start_i | input | 4x7 | Per-descriptor field start bit |
| upd_lenm1_i | input | 4x5 | Per-descriptor field length minus one |
| upd_opnd_i | input | 4x32 | Per-descriptor operand |
| done_o | output | 1 | One-cycle completion pulse |
| old_l1_o | output | 96 | First-level word before update |
| old_l2_o | output | 256 | Second-level word before update |

## Verification
The hardest situation to reach is a request whose second-level address comes from a pointer that the request just ahead of it wrote into the same first-level entry. Here both forwarding paths act in the same request: the first-level forward supplies the pointer, and that pointer then picks a different second-level word. The stimulus table first adds a value into the pointer field of one entry and then, on the next cycle, issues a request to that same entry. Other rows put back-to-back requests with different indices onto one shared second-level word, send a field across bit 127, and force a 4-bit field to wrap, all issued one per cycle.

// File: rtl/statrmw_pkg.sv
package statrmw_pkg;
  localparam int L1_W    = 96;
  localparam int L2_W    = 256;
  localparam int RMW_W   = 128;
  localparam int PTR_LSB = 83;
  localparam int PTR_W   = 13;
  localparam int FLD_MAX = 32;
  localparam int START_W = 7;
  localparam int LEN_W   = 5;
  localparam int N_UPD   = 4;

  typedef struct packed {
    logic               en;
    logic               cst;
    logic [START_W-1:0] start;
    logic [LEN_W-1:0]   lenm1;
    logic [FLD_MAX-1:0] opnd;
  } upd_t;

  // add inside a bit field, wrap within field, leave other bits alone
  function automatic logic [RMW_W-1:0] field_add(input logic [RMW_W-1:0] w,
                                                 input logic [START_W-1:0] start,
                                                 input logic [LEN_W-1:0] lenm1,
                                                 input logic [FLD_MAX-1:0] add);
    logic [FLD_MAX-1:0] m, f;
    logic [RMW_W-1:0]   wm;
    m  = {FLD_MAX{1'b1}} >> (LEN_W'(FLD_MAX - 1) - lenm1);
    f  = FLD_MAX'(w >> start) & m;
    f  = (f + add) & m;
    wm = RMW_W'(m) << start;
    return (w & ~wm) | ((RMW_W'(f) << start) & wm);
  endfunction
endpackage

// File: rtl/statrmw_mem.sv
module statrmw_mem #(
  parameter int W     = 96,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      rdata_o <= '0;
    end else begin
      rdata_o <= mem_q[raddr_i];
      if (we_i) mem_q[waddr_i] <= wdata_i;
    end
  end
endmodule

// File: rtl/statrmw_dual_add.sv
module statrmw_dual_add
  import statrmw_pkg::*;
#(
  parameter int W   = 96,
  parameter int INC = 1
) (
  input  logic [W-1:0] word_i,
  input  upd_t [1:0]   upd_i,
  output logic [W-1:0] word_o
);
  logic [2:0][RMW_W-1:0] chain;

  assign chain[0] = RMW_W'(word_i);

  for (genvar k = 0; k < 2; k++) begin : g_fld
    logic [FLD_MAX-1:0] addend;
    assign addend = upd_i[k].cst ? FLD_MAX'(INC) : upd_i[k].opnd;
    assign chain[k+1] = upd_i[k].en
                        ? field_add(chain[k], upd_i[k].start, upd_i[k].lenm1, addend)
                        : chain[k];
  end

  assign word_o = W'(chain[2]);
endmodule

// File: rtl/statrmw_engine.sv
module statrmw_engine
  import statrmw_pkg::*;
#(
  parameter int L1_DEPTH = 16,
  parameter int L2_DEPTH = 16,
  parameter int INC      = 1,
  localparam int IDX_W   = $clog2(L1_DEPTH),
  localparam int L2_AW   = $clog2(L2_DEPTH)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            valid_i,
  input  logic                            hit_i,
  input  logic [IDX_W-1:0]                idx_i,
  input  logic [N_UPD-1:0]                upd_en_i,
  input  logic [N_UPD-1:0]                upd_cst_i,
  input  logic [N_UPD-1:0][START_W-1:0]   upd_start_i,
  input  logic [N_UPD-1:0][LEN_W-1:0]     upd_lenm1_i,
  input  logic [N_UPD-1:0][FLD_MAX-1:0]   upd_opnd_i,
  output logic                            done_o,
  output logic [L1_W-1:0]                 old_l1_o,
  output logic [L2_W-1:0]                 old_l2_o
);
  upd_t [N_UPD-1:0] upd_in;
  for (genvar k = 0; k < N_UPD; k++) begin : g_upd
    assign upd_in[k] = '{en: upd_en_i[k], cst: upd_cst_i[k], start: upd_start_i[k],
                         lenm1: upd_lenm1_i[k], opnd: upd_opnd_i[k]};
  end

  // stage 1: level-one modify/write
  logic             s1_v, s1_hit, s1_fwd;
  logic [IDX_W-1:0] s1_idx;
  upd_t [N_UPD-1:0] s1_upd;
  logic [L1_W-1:0]  s1_fwd_word, l1_rd, l1_old, l1_new;
  logic             l1_we;
  logic [L2_AW-1:0] l2_ptr;

  // stage 2: level-two modify/write
  logic             s2_v, s2_hit, s2_fwd;
  logic [L2_AW-1:0] s2_ptr;
  upd_t [1:0]       s2_upd;
  logic [L1_W-1:0]  s2_old1;
  logic [L2_W-1:0]  s2_fwd_word, l2_rd, l2_old, l2_new;
  logic [RMW_W-1:0] l2_lo_new;
  logic             l2_we;

  statrmw_mem #(.W(L1_W), .DEPTH(L1_DEPTH)) u_l1_mem (
    .clk_i, .rst_ni, .we_i(l1_we), .waddr_i(s1_idx), .wdata_i(l1_new),
    .raddr_i(idx_i), .rdata_o(l1_rd)
  );

  assign l1_old = s1_fwd ? s1_fwd_word : l1_rd;
  assign l1_we  = s1_v & s1_hit;
  assign l2_ptr = l1_old[PTR_LSB +: L2_AW];

  statrmw_dual_add #(.W(L1_W), .INC(INC)) u_l1_add (
    .word_i(l1_old), .upd_i(s1_upd[1:0]), .word_o(l1_new)
  );

  statrmw_mem #(.W(L2_W), .DEPTH(L2_DEPTH)) u_l2_mem (
    .clk_i, .rst_ni, .we_i(l2_we), .waddr_i(s2_ptr), .wdata_i(l2_new),
    .raddr_i(l2_ptr), .rdata_o(l2_rd)
  );

  assign l2_old = s2_fwd ? s2_fwd_word : l2_rd;
  assign l2_we  = s2_v & s2_hit;

  statrmw_dual_add #(.W(RMW_W), .INC(INC)) u_l2_add (
    .word_i(l2_old[RMW_W-1:0]), .upd_i(s2_upd), .word_o(l2_lo_new)
  );
  assign l2_new = {l2_old[L2_W-1:RMW_W], l2_lo_new};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_v <= 1'b0; s1_hit <= 1'b0; s1_idx <= '0; s1_upd <= '0;
      s1_fwd <= 1'b0; s1_fwd_word <= '0;
      s2_v <= 1'b0; s2_hit <= 1'b0; s2_ptr <= '0; s2_upd <= '0; s2_old1 <= '0;
      s2_fwd <= 1'b0; s2_fwd_word <= '0;
      done_o <= 1'b0; old_l1_o <= '0; old_l2_o <= '0;
    end else begin
      s1_v   <= valid_i;
      s1_hit <= hit_i;
      s1_idx <= idx_i;
      s1_upd <= upd_in;
      // array read at this edge misses the write landing at the same edge
      s1_fwd      <= valid_i & l1_we & (idx_i == s1_idx);
      s1_fwd_word <= l1_new;

      s2_v    <= s1_v;
      s2_hit  <= s1_hit;
      s2_ptr  <= l2_ptr;
      s2_upd  <= s1_upd[3:2];
      s2_old1 <= l1_old;
      s2_fwd      <= s1_v & l2_we & (l2_ptr == s2_ptr);
      s2_fwd_word <= l2_new;

      done_o   <= s2_v;
      old_l1_o <= s2_old1;
      old_l2_o <= l2_old;
    end
  end
endmodule

// File: rtl/statrmw_engine_chk.sv
module statrmw_engine_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic valid_i,
  input logic hit_i,
  input logic done_o,
  input logic l1_we,
  input logic l2_we
);
  logic [2:0] v_sr;
  logic [1:0] h_sr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_sr <= '0;
      h_sr <= '0;
    end else begin
      v_sr <= {v_sr[1:0], valid_i};
      h_sr <= {h_sr[0], hit_i};
    end
  end

  a_r2_done_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o == v_sr[2]);
  a_r2_done_known: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$isunknown(done_o));
  a_r9_l1_write_on_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l1_we == (v_sr[0] && h_sr[0]));
  a_r9_l2_write_on_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l2_we == (v_sr[1] && h_sr[1]));
  a_r12_l2_follows_l1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l2_we |-> $past(l1_we));
endmodule

bind statrmw_engine statrmw_engine_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .hit_i(hit_i),
  .done_o(done_o), .l1_we(l1_we), .l2_we(l2_we)
);

// File: tb/statrmw_engine_tb.sv
module statrmw_engine_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic valid = 1'b0, hit = 1'b0;
  logic [3:0] idx = '0, en = '0, cst = '0;
  logic [3:0][6:0] st = '0;
  logic [3:0][4:0] ln = '0;
  logic [3:0][31:0] op = '0;
  logic done;
  logic [95:0] old1;
  logic [255:0] old2;

  always #5 clk = ~clk;

  statrmw_engine u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .hit_i(hit), .idx_i(idx),
    .upd_en_i(en), .upd_cst_i(cst), .upd_start_i(st), .upd_lenm1_i(ln),
    .upd_opnd_i(op), .done_o(done), .old_l1_o(old1), .old_l2_o(old2)
  );

  typedef struct packed {
    logic [3:0] idx; logic hit; logic [3:0] en; logic [3:0] cst;
    logic [3:0][6:0] st; logic [3:0][4:0] ln; logic [31:0] op;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{4'd1, 1'b1, 4'hF, 4'h0, {7'd64, 7'd0, 7'd32, 7'd0}, {5'd7, 5'd31, 5'd31, 5'd15}, 32'd5},
    '{4'd1, 1'b1, 4'hF, 4'h0, {7'd64, 7'd0, 7'd32, 7'd0}, {5'd7, 5'd31, 5'd31, 5'd15}, 32'd5},
    '{4'd2, 1'b1, 4'hB, 4'h0, {7'd8, 7'd0, 7'd0, 7'd83},  {5'd7, 5'd0, 5'd3, 5'd12},   32'd3},
    '{4'd2, 1'b1, 4'hF, 4'h0, {7'd120, 7'd0, 7'd0, 7'd4}, {5'd15, 5'd31, 5'd3, 5'd3},  32'hFFFF},
    '{4'd5, 1'b0, 4'hF, 4'h0, {7'd64, 7'd0, 7'd32, 7'd0}, {5'd7, 5'd31, 5'd31, 5'd15}, 32'd9},
    '{4'd7, 1'b1, 4'hF, 4'hF, {7'd64, 7'd0, 7'd32, 7'd0}, {5'd7, 5'd31, 5'd31, 5'd15}, 32'd100},
    '{4'd1, 1'b1, 4'hF, 4'h0, {7'd64, 7'd0, 7'd32, 7'd0}, {5'd7, 5'd31, 5'd31, 5'd15}, 32'd7},
    '{4'd2, 1'b1, 4'h3, 4'h0, {7'd0, 7'd0, 7'd0, 7'd0},   {5'd0, 5'd0, 5'd0, 5'd0},    32'd1},
    '{4'd2, 1'b1, 4'hC, 4'h0, {7'd0, 7'd0, 7'd0, 7'd0},   {5'd31, 5'd31, 5'd0, 5'd0},  32'd1}
  };

  function automatic string tag_of(int i);
    case (i)
      0: return "R4";
      1: return "R10";
      2: return "R6 R8";
      3: return "R7 R11";
      4: return "R9";
      5: return "R5";
      6: return "R12";
      7: return "R8";
      default: return "R6";
    endcase
  endfunction

  // bench model
  logic [95:0]  m1 [16];
  logic [255:0] m2 [16];
  logic [95:0]  e1 [64];
  logic [255:0] e2 [64];
  int           ecyc [64];
  string        etag [64];
  int wr = 0, rd = 0, cyc = 0, checks = 0, fails = 0;
  bit finished = 0;

  function automatic logic [127:0] m_add(logic [127:0] w, int start, int lenm1, logic [31:0] a);
    logic [31:0] f = '0;
    for (int i = 0; i <= lenm1; i++) if (start + i < 128) f[i] = w[start+i];
    f = f + a;
    for (int i = 0; i <= lenm1; i++) if (start + i < 128) w[start+i] = f[i];
    return w;
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [255:0] act, logic [255:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int i = 0; i < 16; i++) begin m1[i] = '0; m2[i] = '0; end
    wr = 0; rd = 0;
  endtask

  // called at a negedge; returns at the next negedge
  task automatic issue(vec_t v, string tag);
    logic [95:0] o1; logic [255:0] o2; logic [127:0] w; int p;
    o1 = m1[v.idx];
    p  = int'(o1[86:83]);
    if (v.hit) begin
      w = {32'b0, o1};
      for (int k = 0; k < 2; k++)
        if (v.en[k]) w = m_add(w, int'(v.st[k]), int'(v.ln[k]), v.cst[k] ? 32'd1 : v.op);
      m1[v.idx] = w[95:0];
    end
    o2 = m2[p];
    if (v.hit) begin
      w = o2[127:0];
      for (int k = 2; k < 4; k++)
        if (v.en[k]) w = m_add(w, int'(v.st[k]), int'(v.ln[k]), v.cst[k] ? 32'd1 : v.op);
      m2[p] = {o2[255:128], w};
    end
    e1[wr % 64] = o1; e2[wr % 64] = o2; ecyc[wr % 64] = cyc + 3; etag[wr % 64] = tag;
    wr++;
    valid = 1'b1; hit = v.hit; idx = v.idx; en = v.en; cst = v.cst;
    st = v.st; ln = v.ln; op = {4{v.op}};
    @(negedge clk);
  endtask

  task automatic idle(int n);
    valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // R2 R3: every done pulse matches the oldest outstanding request
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (rd == wr) chk(1'b0, "R2", "unexpected done", 256'(done), 256'(0));
      else begin
        chk(cyc == ecyc[rd % 64], {etag[rd % 64], " R2"}, "done cycle", 256'(cyc), 256'(ecyc[rd % 64]));
        chk(old1 == e1[rd % 64], {etag[rd % 64], " R3"}, "old_l1", 256'(old1), 256'(e1[rd % 64]));
        chk(old2 == e2[rd % 64], {etag[rd % 64], " R3"}, "old_l2", old2, e2[rd % 64]);
        rd++;
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    clear_model();
    repeat (2) @(negedge clk);
    // R1: reset state
    chk(done == 1'b0, "R1", "done in reset", 256'(done), 256'(0));
    chk(old1 == '0, "R1", "old_l1 in reset", 256'(old1), 256'(0));
    chk(old2 == '0, "R1", "old_l2 in reset", old2, 256'(0));
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) issue(VEC[i], tag_of(i));
    idle(6);
    chk(rd == wr, "R2", "all requests completed", 256'(rd), 256'(wr));

    // spaced requests re-read state left by the table
    issue('{4'd2, 1'b1, 4'h0, 4'h0, '0, '0, 32'd0}, "R6");
    idle(4);
    issue('{4'd1, 1'b1, 4'h0, 4'h0, '0, '0, 32'd0}, "R10 R12");
    idle(4);
    issue('{4'd5, 1'b1, 4'h0, 4'h0, '0, '0, 32'd0}, "R9");
    idle(4);

    // R1: mid-run reset clears both arrays
    issue('{4'd3, 1'b1, 4'hF, 4'h0, {7'd0, 7'd0, 7'd0, 7'd0}, '0, 32'd9}, "R4");
    rst_n = 1'b0;
    clear_model();
    @(negedge clk);
    chk(done == 1'b0, "R1", "done after reset", 256'(done), 256'(0));
    chk(old1 == '0, "R1", "old_l1 after reset", 256'(old1), 256'(0));
    idle(2);
    rst_n = 1'b1;
    @(negedge clk);
    issue('{4'd1, 1'b1, 4'h0, 4'h0, '0, '0, 32'd0}, "R1");
    issue('{4'd3, 1'b1, 4'h0, 4'h0, '0, '0, 32'd0}, "R1");
    idle(6);
    chk(rd == wr, "R2", "drain after reset", 256'(rd), 256'(wr));
    summary();
  end
endmodule